// File: doc/BRIEF.md
# Counterflow Systolic Vector-Matrix Multiplier

The block multiplies a row vector `x` of length N by an N-by-N matrix `A` and returns the row vector `y = xA`, with `y_j` equal to the sum over `i` of `x_i * a_ij`. It is built as a linear chain of 2N-1 processing cells. Elements of `x` move one cell upward per clock. Partial sums of `y` move one cell downward per clock, starting from zero. The matrix coefficients stay in the cells. Cell `p` holds the coefficients whose column index minus row index equals `p-(N-1)`. When an `x_i` and a `y_j` sit in the same cell during a cycle, that cell adds `a_ij * x_i` into `y_j` as the partial sum moves on. Every value moves only between neighbouring cells.

Software first fills the coefficients through a write port. It then presents a vector as a burst of N consecutive valid cycles. The block stages the burst and launches one `x` element and one zeroed `y` element every second cycle. Four phases overlap in sequence: input, execution with input, execution only, and execution with output. Finished `y` elements leave in index order on every second cycle.

Top module: `sysmv_counterflow`

## Requirements
- R1: After a vector is processed, the output element with index j equals the sum over i of x_i times a_ij, computed modulo 2^32.
- R2: Every partial sum starts from zero. A vector started on the first cycle after the previous one finished gives results that do not depend on the earlier vector.
- R3: On each cycle, every x element moves exactly one cell toward the top of the chain and every partial sum moves exactly one cell toward the bottom. An x element and a partial sum that share a cell always satisfy column index minus row index equal to that cell's position minus (N-1).
- R4: A coefficient write (`cf_we` with row `cf_row`, column `cf_col`, value `cf_data`) takes effect when `busy` is low in that cycle, including the cycle in which the first element of a vector is taken. A write in any cycle with `busy` high is ignored, both by the vector in flight and by later vectors. Zero coefficients add nothing.
- R5: A vector is taken as `x_valid` high on N consecutive cycles while idle, with element index i in burst position i. `x_valid` cycles after the burst, while `busy` is high, are ignored.
- R6: Let the first element be taken at clock edge E. Output j is then shown with `y_valid` high and `y_idx` = j in the cycle after edge E+2N+2j. `y_valid` is high for exactly N cycles per vector and never on two consecutive cycles.
- R7: `busy` rises at edge E and falls at edge E+4N-2, which is the same edge at which the last output appears. A new vector may start on the next edge.
- R8: Accumulation wraps modulo 2^32. With all inputs and coefficients at 65535 and N=4, every output is 0xFFF80004.
- R9: After reset, `busy` and `y_valid` are low and every coefficient is zero, so a vector run with no writes yields all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cf_we | input | 1 | Coefficient write strobe |
| cf_row | input | IW | Row index i of the coefficient |
| cf_col | input | IW | Column index j of the coefficient |
| cf_data | input | DW | Coefficient value |
| x_valid | input | 1 | Input element valid |
| x_data | input | DW | Input element value |
| busy | output | 1 | A vector is in flight |
| y_valid | output | 1 | Output element valid |
| y_idx | output | IW | Index j of the output element |
| y_data | output | AW | Value of y_j |

## Verification
Two functions of this block can meet in one cycle. A coefficient write can arrive on the same clock as the first x element that starts a run. A coefficient write or a stray `x_valid` can also arrive while a run is already under way. The bench covers both. In one run it rewrites a coefficient on the edge that takes x_0, and expects the new value to appear in that run's outputs. In another run it drives stray input elements and a conflicting write while `busy` is high. It then expects that run's outputs, and the outputs of the following run, to reflect only the coefficients held before the run started.

// File: rtl/sysmv_pkg.sv
package sysmv_pkg;

    // Width of an index tag for a vector of n elements.
    function automatic int unsigned tag_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Number of cells in the counterflow chain.
    function automatic int unsigned chain_len(input int unsigned n);
        return 2 * n - 1;
    endfunction

    // Sequencer step at which a run ends (last output registered).
    function automatic int unsigned final_step(input int unsigned n);
        return 4 * n - 3;
    endfunction

    // Cell position where x_i meets y_j.
    function automatic int meet_cell(input int i, input int j, input int n);
        return n - 1 + j - i;
    endfunction

endpackage

// File: rtl/mv_feeder.sv
module mv_feeder
    import sysmv_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned DW = 16,
    parameter int unsigned IW = tag_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          x_valid,
    input  logic [DW-1:0] x_data,
    output logic          busy,
    output logic          inj_vld,
    output logic [IW-1:0] inj_tag,
    output logic [DW-1:0] inj_dat
);
    localparam int unsigned LAST = final_step(N);
    localparam int unsigned CW   = $clog2(LAST + 1);

    logic          busy_q;
    logic [CW-1:0] step_q;
    logic [IW:0]   fill_q;
    logic [DW-1:0] stage_q [N];
    logic [CW-1:0] half;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            step_q <= '0;
            fill_q <= '0;
            for (int k = 0; k < N; k++) stage_q[k] <= '0;
        end else if (!busy_q) begin
            if (x_valid) begin
                busy_q     <= 1'b1;
                step_q     <= '0;
                stage_q[0] <= x_data;
                fill_q     <= (IW+1)'(1);
            end
        end else begin
            if (x_valid && (int'(fill_q) < N)) begin
                stage_q[fill_q[IW-1:0]] <= x_data;
                fill_q <= fill_q + 1'b1;
            end
            if (int'(step_q) == LAST) busy_q <= 1'b0;
            step_q <= step_q + 1'b1;
        end
    end

    always_comb begin
        half    = step_q >> 1;
        inj_vld = busy_q && !step_q[0] && (int'(half) < N);
        inj_tag = IW'(half);
        inj_dat = stage_q[inj_tag];
    end

    assign busy = busy_q;

    // R5: a run starts only on a cycle that presented an element
    p_start_on_valid_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(x_valid));

    // R7: the sequencer never runs past its final step
    p_step_bound_r7: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> int'(step_q) <= LAST);

endmodule

// File: rtl/mv_cell.sv
module mv_cell
    import sysmv_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 32,
    parameter int unsigned IW = tag_width(N),
    parameter int          D  = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_row,
    input  logic [IW-1:0] wr_col,
    input  logic [DW-1:0] wr_data,
    input  logic          x_vld,
    input  logic [IW-1:0] x_tag,
    input  logic [DW-1:0] x_dat,
    input  logic          y_vld,
    input  logic [IW-1:0] y_tag,
    output logic          fire,
    output logic [AW-1:0] prod
);
    logic [DW-1:0] bank_q [N];
    logic [DW-1:0] coef;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) bank_q[k] <= '0;
        end else if (wr_en && (int'(wr_col) - int'(wr_row) == D)) begin
            bank_q[wr_row] <= wr_data;
        end
    end

    always_comb begin
        coef = bank_q[x_tag];
        fire = x_vld && y_vld && (int'(y_tag) - int'(x_tag) == D) && (coef != '0);
        prod = fire ? (AW'(coef) * AW'(x_dat)) : '0;
    end

    // R3: the counterflow schedule only ever pairs x_i with y_j on this diagonal
    p_meet_diag_r3: assert property (@(posedge clk) disable iff (rst)
        (x_vld && y_vld) |-> (int'(y_tag) - int'(x_tag) == D));

endmodule

// File: rtl/sysmv_counterflow.sv
module sysmv_counterflow
    import sysmv_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 32,
    parameter int unsigned IW = tag_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cf_we,
    input  logic [IW-1:0] cf_row,
    input  logic [IW-1:0] cf_col,
    input  logic [DW-1:0] cf_data,
    input  logic          x_valid,
    input  logic [DW-1:0] x_data,
    output logic          busy,
    output logic          y_valid,
    output logic [IW-1:0] y_idx,
    output logic [AW-1:0] y_data
);
    localparam int unsigned L = chain_len(N);

    typedef struct packed {
        logic          v;
        logic [IW-1:0] t;
        logic [DW-1:0] d;
    } xel_t;

    typedef struct packed {
        logic          v;
        logic [IW-1:0] t;
        logic [AW-1:0] d;
    } yel_t;

    xel_t          xq [L];
    yel_t          yq [L];
    logic [AW-1:0] prod [L];
    logic [L-1:0]  fire;

    logic          inj_vld;
    logic [IW-1:0] inj_tag;
    logic [DW-1:0] inj_dat;
    logic          wr_ok;

    mv_feeder #(.N(N), .DW(DW), .IW(IW)) u_feed (
        .clk     (clk),
        .rst     (rst),
        .x_valid (x_valid),
        .x_data  (x_data),
        .busy    (busy),
        .inj_vld (inj_vld),
        .inj_tag (inj_tag),
        .inj_dat (inj_dat)
    );

    assign wr_ok = cf_we && !busy;

    for (genvar p = 0; p < L; p++) begin : g_cell
        mv_cell #(.N(N), .DW(DW), .AW(AW), .IW(IW), .D(p - (int'(N) - 1))) u_cell (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_ok),
            .wr_row  (cf_row),
            .wr_col  (cf_col),
            .wr_data (cf_data),
            .x_vld   (xq[p].v),
            .x_tag   (xq[p].t),
            .x_dat   (xq[p].d),
            .y_vld   (yq[p].v),
            .y_tag   (yq[p].t),
            .fire    (fire[p]),
            .prod    (prod[p])
        );
    end

    // x climbs, partial sums descend, one cell per clock
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < L; p++) begin
                xq[p] <= '0;
                yq[p] <= '0;
            end
            y_valid <= 1'b0;
            y_idx   <= '0;
            y_data  <= '0;
        end else begin
            xq[0] <= '{v: inj_vld, t: inj_tag, d: inj_dat};
            for (int p = 1; p < L; p++) xq[p] <= xq[p-1];
            yq[L-1] <= '{v: inj_vld, t: inj_tag, d: '0};
            for (int p = 0; p < L - 1; p++)
                yq[p] <= '{v: yq[p+1].v, t: yq[p+1].t, d: yq[p+1].d + prod[p+1]};
            y_valid <= yq[0].v;
            if (yq[0].v) begin
                y_idx  <= yq[0].t;
                y_data <= yq[0].d + prod[0];
            end
        end
    end

    // Assertion support: index the next output must carry
    logic [IW-1:0] out_seq;
    always_ff @(posedge clk) begin
        if (rst) out_seq <= '0;
        else if (y_valid) out_seq <= (int'(out_seq) == N - 1) ? '0 : out_seq + 1'b1;
    end

    for (genvar p = 1; p < L; p++) begin : g_hop
        // R3: an x element in cell p was in cell p-1 one cycle earlier
        p_x_hop_r3: assert property (@(posedge clk) disable iff (rst)
            xq[p].v |-> $past(xq[p-1].v));
        // R3: a partial sum in cell p-1 was in cell p one cycle earlier
        p_y_hop_r3: assert property (@(posedge clk) disable iff (rst)
            yq[p-1].v |-> $past(yq[p].v));
    end

    // R6: outputs are spaced apart
    p_out_gap_r6: assert property (@(posedge clk) disable iff (rst)
        y_valid |=> !y_valid);

    // R6: outputs leave in index order
    p_out_order_r6: assert property (@(posedge clk) disable iff (rst)
        y_valid |-> (y_idx == out_seq));

    // R7: the run ends together with its last output
    p_end_with_last_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (y_valid && int'(y_idx) == N - 1));

    // R9: idle chain carries no work
    p_idle_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> !y_valid);

endmodule

// File: tb/sim_sysmv_counterflow.sv
module sim_sysmv_counterflow;
    localparam int N  = 4;
    localparam int DW = 16;
    localparam int AW = 32;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          cf_we;
    logic [IW-1:0] cf_row, cf_col;
    logic [DW-1:0] cf_data;
    logic          x_valid;
    logic [DW-1:0] x_data;
    logic          busy, y_valid;
    logic [IW-1:0] y_idx;
    logic [AW-1:0] y_data;

    int n_chk  = 0;
    int n_fail = 0;

    logic [DW-1:0] mat   [N][N];
    logic [DW-1:0] vec_x [N];

    always #10 clk = ~clk;   // 50 MHz

    sysmv_counterflow #(.N(N), .DW(DW), .AW(AW), .IW(IW)) u0 (
        .clk(clk), .rst(rst), .cf_we(cf_we), .cf_row(cf_row), .cf_col(cf_col),
        .cf_data(cf_data), .x_valid(x_valid), .x_data(x_data), .busy(busy),
        .y_valid(y_valid), .y_idx(y_idx), .y_data(y_data)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // We are at a negedge on entry and exit of every task.
    task automatic write_coef(input int i, input int j, input logic [DW-1:0] v);
        cf_we = 1'b1; cf_row = IW'(i); cf_col = IW'(j); cf_data = v;
        mat[i][j] = v;
        @(negedge clk);
        cf_we = 1'b0;
    endtask

    task automatic clear_coefs();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) write_coef(i, j, '0);
    endtask

    // Runs vec_x; optional junk input and write during busy; optional write with x_0.
    task automatic run_vec(input string req, input bit junk, input bit same_wr,
                           input int sw_i, input int sw_j, input logic [DW-1:0] sw_v);
        logic [AW-1:0] expv [N];
        int outs;
        if (same_wr) begin
            cf_we = 1'b1; cf_row = IW'(sw_i); cf_col = IW'(sw_j); cf_data = sw_v;
            mat[sw_i][sw_j] = sw_v;
        end
        for (int j = 0; j < N; j++) begin
            expv[j] = '0;
            for (int i = 0; i < N; i++)
                expv[j] = expv[j] + AW'(mat[i][j]) * AW'(vec_x[i]);
        end
        x_valid = 1'b1; x_data = vec_x[0];
        @(posedge clk);   // edge E
        outs = 0;
        for (int k = 0; k <= 4 * N - 2; k++) begin
            @(negedge clk);
            cf_we = 1'b0;
            if (k < N - 1) begin
                x_valid = 1'b1; x_data = vec_x[k+1];
            end else if (junk && k < 4 * N - 2) begin
                x_valid = 1'b1; x_data = DW'(16'hBEEF + k);   // R5: ignored while busy
                if (k == N + 1) begin                         // R4: ignored write
                    cf_we = 1'b1; cf_row = '0; cf_col = '0; cf_data = 16'd999;
                end
            end else begin
                x_valid = 1'b0;
            end
            if (k == 0) check("R7", {req, " busy after start"}, busy, 1);
            if (k == 4 * N - 2) check("R7", {req, " busy cleared"}, busy, 0);
            if (y_valid) begin
                check("R6", {req, " output cycle"}, k, 2 * N + 2 * outs);
                check("R6", {req, " output index"}, y_idx, outs);
                if (outs < N) check(req, $sformatf("y%0d value", outs), y_data, expv[outs]);
                outs++;
            end
        end
        cf_we = 1'b0;
        x_valid = 1'b0;
        check("R6", {req, " output count"}, outs, N);
    endtask

    task automatic t_reset();
        check("R9", "busy after reset", busy, 0);
        check("R9", "y_valid after reset", y_valid, 0);
        vec_x = '{16'd7, 16'd8, 16'd9, 16'd10};
        run_vec("R9", 0, 0, 0, 0, '0);
    endtask

    task automatic t_sparse();
        clear_coefs();
        write_coef(0, 0, 16'd1); write_coef(3, 0, 16'd6); write_coef(1, 2, 16'd3);
        write_coef(2, 1, 16'd4); write_coef(0, 3, 16'd2); write_coef(2, 3, 16'd5);
        vec_x = '{16'd1, 16'd2, 16'd3, 16'd4};
        run_vec("R1", 0, 0, 0, 0, '0);   // expects 25, 12, 6, 17
    endtask

    task automatic t_dense();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) write_coef(i, j, DW'(i * N + j + 1));
        vec_x = '{16'd5, 16'd6, 16'd7, 16'd8};
        run_vec("R1", 0, 0, 0, 0, '0);
    endtask

    task automatic t_back_to_back();
        vec_x = '{16'd100, 16'd0, 16'd3, 16'd1};
        run_vec("R2", 0, 0, 0, 0, '0);
        vec_x = '{16'd2, 16'd4, 16'd0, 16'd9};
        run_vec("R2", 0, 0, 0, 0, '0);   // starts on the edge after busy falls
    endtask

    task automatic t_busy_ignore();
        vec_x = '{16'd1, 16'd1, 16'd1, 16'd1};
        run_vec("R5", 1, 0, 0, 0, '0);
        run_vec("R4", 0, 0, 0, 0, '0);   // a00 must still be 1, not 999
    endtask

    task automatic t_same_cycle();
        vec_x = '{16'd3, 16'd0, 16'd0, 16'd0};
        run_vec("R4", 0, 1, 0, 0, 16'd50);   // new a00 applies to this run
    endtask

    task automatic t_overflow();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) write_coef(i, j, 16'hFFFF);
        vec_x = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};
        run_vec("R8", 0, 0, 0, 0, '0);   // each output 0xFFF80004
    endtask

    initial begin
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) mat[i][j] = '0;
        rst = 1'b1; cf_we = 1'b0; cf_row = '0; cf_col = '0; cf_data = '0;
        x_valid = 1'b0; x_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sparse();
        t_dense();
        t_back_to_back();
        t_busy_ignore();
        t_same_cycle();
        t_overflow();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule